// File: doc/BRIEF.md
# SDRAM Command Sequencer with Per-Bank Row Tracking

The block accepts single read, write and mode-load requests on a valid/ready user port. It turns each one into the sequence of SDRAM commands it needs on the chip-select, RAS#, CAS#, WE#, bank-address and address pins. A row-tracking table keeps, for each bank, whether a row is open and which row that is. A read or write that hits the open row goes out at once. A request to a closed bank is preceded by ACTIVE. A request to a different row first closes the bank with PRECHARGE and then opens the new row.

Bank recovery (ACTIVE-to-access, PRECHARGE-to-ACTIVE, auto-precharge) and the mode-register wait are counted in clock cycles, and module parameters set each count. A mode load closes every open bank with one all-bank PRECHARGE before it is issued. While a request is held, the pins carry NOP on wait cycles. With no request held, the pins carry a deselect.

Top module: `sdram_cmd_seq`

## Requirements
- R1: The pin command {cs_n, ras_n, cas_n, we_n} uses these codes: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, LOAD MODE 0000, deselect 1111. Deselect is driven when no request is held. NOP is driven on every wait cycle between the commands of one request.
- R2: A request is taken when req_valid_i and req_ready_o are both high. req_ready_o is high out of reset. It is low while a request is held and while any bank or mode-register counter is still running. After a READ or WRITE without auto-precharge, it is high again in the cycle that command appears on the pins.
- R3: A read (req_op_i = 00) or write (req_op_i = 01) to a bank with no open row issues ACTIVE (BA = bank, A = row), and then, exactly T_RCD cycles later, the access.
- R4: An access to the row already open in its bank issues only the READ or WRITE, with no ACTIVE or PRECHARGE in front of it.
- R5: An access to a bank whose open row differs issues PRECHARGE to that bank (A10 = 0), then ACTIVE for the new row exactly T_RP cycles later, then the access exactly T_RCD cycles after that.
- R6: READ and WRITE drive the bank on BA, the column on A[8:0], the auto-precharge flag on A10 and zero on A9 and A11.
- R7: An access with auto-precharge closes that bank's row. req_ready_o goes high again exactly BURST_LEN + T_RP - 1 cycles after the cycle the access is on the pins. A later access to that bank starts with ACTIVE, and that ACTIVE is no sooner than BURST_LEN + T_RP cycles after the access.
- R8: A mode load (req_op_i[1] = 1) with any bank open first issues PRECHARGE with A10 = 1 and BA = 0. LOAD MODE follows exactly T_RP cycles later. LOAD MODE is only ever issued with every bank closed and carries req_bank_i on BA and req_row_i on A.
- R9: After LOAD MODE, no other command except NOP or deselect appears for T_MRD cycles. req_ready_o stays low and rises exactly T_MRD - 1 cycles after LOAD MODE is on the pins.
- R10: Opening, accessing or closing a row in one bank leaves the open rows of the other banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken |
| req_op_i | input | 2 | 00 read, 01 write, 1x mode load |
| req_bank_i | input | BA_W | Bank; for a mode load, the BA value |
| req_row_i | input | ROW_W | Row; for a mode load, the A value |
| req_col_i | input | COL_W | Starting column |
| req_ap_i | input | 1 | Auto-precharge after the access |
| sd_cs_no | output | 1 | Chip select, active low |
| sd_ras_no | output | 1 | Row strobe, active low |
| sd_cas_no | output | 1 | Column strobe, active low |
| sd_we_no | output | 1 | Write enable, active low |
| sd_ba_o | output | BA_W | Bank address |
| sd_addr_o | output | ROW_W | Address bus |

## Verification
Every bank is driven through four request patterns:
- an access to a closed bank, which separates ACTIVE-then-access from a direct access;
- a repeat to the same row, which shows the row is reused and that the other banks' rows survived;
- an access to a new row, which must produce the PRECHARGE, ACTIVE, access triple with exact spacing;
- an auto-precharge access followed at once by another access to the same bank, which measures the ready window and forces a fresh ACTIVE.

Mode loads are tried both with all four banks open and with every bank closed. This separates the all-bank PRECHARGE path from a bare LOAD MODE. The ready timing that follows each mode load tells a correct wait from a short one.

// File: rtl/sdram_seq_pkg.sv
`timescale 1ns/1ps
package sdram_seq_pkg;
  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111,
    CMD_INH = 4'b1111
  } sd_cmd_e;

  typedef enum logic {ST_IDLE, ST_EXEC} seq_state_e;
endpackage

// File: rtl/sdram_wait_cnt.sv
`timescale 1ns/1ps
module sdram_wait_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/sdram_bank_track.sv
`timescale 1ns/1ps
module sdram_bank_track #(
  parameter int unsigned BA_W      = 2,
  parameter int unsigned ROW_W     = 12,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned NUM_BANKS = 1 << BA_W
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           act_i,
  input  logic                           pre_i,
  input  logic                           pre_all_i,
  input  logic                           ap_close_i,
  input  logic [BA_W-1:0]                bank_i,
  input  logic [ROW_W-1:0]               row_i,
  output logic [NUM_BANKS-1:0]           open_o,
  output logic [NUM_BANKS-1:0][ROW_W-1:0] rows_o,
  output logic [NUM_BANKS-1:0]           busy_o
);
  localparam int unsigned AP_WAIT  = BURST_LEN + T_RP;
  localparam int unsigned MAX_WAIT = (T_RCD > AP_WAIT) ? T_RCD : AP_WAIT;
  localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] RCD_V = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] RP_V  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] AP_V  = CNT_W'(AP_WAIT - 1);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic             hit, ld_act, ld_pre, ld_ap;
    logic [CNT_W-1:0] ld_val;

    assign hit    = (bank_i == BA_W'(g));
    assign ld_act = act_i & hit;
    assign ld_pre = (pre_i & hit) | pre_all_i;
    assign ld_ap  = ap_close_i & hit;
    assign ld_val = ld_act ? RCD_V : (ld_pre ? RP_V : AP_V);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_o[g] <= 1'b0;
        rows_o[g] <= '0;
      end else if (ld_act) begin
        open_o[g] <= 1'b1;
        rows_o[g] <= row_i;
      end else if (ld_pre || ld_ap) begin
        open_o[g] <= 1'b0;
      end
    end

    sdram_wait_cnt #(.CNT_W(CNT_W)) u_wait (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (ld_act | ld_pre | ld_ap),
      .val_i  (ld_val),
      .busy_o (busy_o[g])
    );
  end
endmodule

// File: rtl/sdram_cmd_seq.sv
`timescale 1ns/1ps
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int unsigned BA_W      = 2,
  parameter int unsigned ROW_W     = 12,
  parameter int unsigned COL_W     = 9,
  parameter int unsigned AP_BIT    = 10,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_MRD     = 2,
  parameter int unsigned BURST_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [1:0]       req_op_i,
  input  logic [BA_W-1:0]  req_bank_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic             req_ap_i,
  output logic             sd_cs_no,
  output logic             sd_ras_no,
  output logic             sd_cas_no,
  output logic             sd_we_no,
  output logic [BA_W-1:0]  sd_ba_o,
  output logic [ROW_W-1:0] sd_addr_o
);
  localparam int unsigned NUM_BANKS = 1 << BA_W;
  localparam int unsigned MRD_W     = $clog2(T_MRD + 1);
  localparam logic [MRD_W-1:0] MRD_V = MRD_W'(T_MRD - 1);

  seq_state_e       state_q;
  logic [1:0]       op_q;
  logic [BA_W-1:0]  bank_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             ap_q;

  sd_cmd_e          cmd_d, cmd_q;
  logic [BA_W-1:0]  ba_d, ba_q;
  logic [ROW_W-1:0] addr_d, addr_q;
  logic             act_s, pre_s, pre_all_s, ap_close_s, mrd_ld_s, done_s;

  logic [NUM_BANKS-1:0]            bank_open, bank_busy;
  logic [NUM_BANKS-1:0][ROW_W-1:0] bank_rows;
  logic                            mrd_busy;
  logic                            accept;

  sdram_bank_track #(
    .BA_W(BA_W), .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP), .BURST_LEN(BURST_LEN)
  ) u_banks (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act_s),
    .pre_i      (pre_s),
    .pre_all_i  (pre_all_s),
    .ap_close_i (ap_close_s),
    .bank_i     (bank_q),
    .row_i      (row_q),
    .open_o     (bank_open),
    .rows_o     (bank_rows),
    .busy_o     (bank_busy)
  );

  sdram_wait_cnt #(.CNT_W(MRD_W)) u_mrd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (mrd_ld_s),
    .val_i  (MRD_V),
    .busy_o (mrd_busy)
  );

  assign req_ready_o = (state_q == ST_IDLE) && !mrd_busy && !(|bank_busy);
  assign accept      = req_valid_i && req_ready_o;

  // next command for the held request; waits resolve to NOP
  always_comb begin
    cmd_d      = (state_q == ST_EXEC) ? CMD_NOP : CMD_INH;
    ba_d       = '0;
    addr_d     = '0;
    act_s      = 1'b0;
    pre_s      = 1'b0;
    pre_all_s  = 1'b0;
    ap_close_s = 1'b0;
    mrd_ld_s   = 1'b0;
    done_s     = 1'b0;
    if (state_q == ST_EXEC && !mrd_busy) begin
      if (op_q[1]) begin
        if (!(|bank_busy)) begin
          if (|bank_open) begin
            cmd_d          = CMD_PRE;
            addr_d[AP_BIT] = 1'b1;
            pre_all_s      = 1'b1;
          end else begin
            cmd_d    = CMD_LMR;
            ba_d     = bank_q;
            addr_d   = row_q;
            mrd_ld_s = 1'b1;
            done_s   = 1'b1;
          end
        end
      end else if (!bank_busy[bank_q]) begin
        if (bank_open[bank_q] && bank_rows[bank_q] == row_q) begin
          cmd_d               = op_q[0] ? CMD_WR : CMD_RD;
          ba_d                = bank_q;
          addr_d[COL_W-1:0]   = col_q;
          addr_d[AP_BIT]      = ap_q;
          ap_close_s          = ap_q;
          done_s              = 1'b1;
        end else if (bank_open[bank_q]) begin
          cmd_d = CMD_PRE;
          ba_d  = bank_q;
          pre_s = 1'b1;
        end else begin
          cmd_d  = CMD_ACT;
          ba_d   = bank_q;
          addr_d = row_q;
          act_s  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      bank_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      ap_q    <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      if (accept) begin
        state_q <= ST_EXEC;
        op_q    <= req_op_i;
        bank_q  <= req_bank_i;
        row_q   <= req_row_i;
        col_q   <= req_col_i;
        ap_q    <= req_ap_i;
      end
    end else if (done_s) begin
      state_q <= ST_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_INH;
      ba_q   <= '0;
      addr_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
    end
  end

  assign {sd_cs_no, sd_ras_no, sd_cas_no, sd_we_no} = cmd_q;
  assign sd_ba_o   = ba_q;
  assign sd_addr_o = addr_q;
endmodule

// File: rtl/sdram_cmd_seq_chk.sv
`timescale 1ns/1ps
module sdram_cmd_seq_chk
  import sdram_seq_pkg::*;
#(
  parameter int unsigned BA_W      = 2,
  parameter int unsigned T_RCD     = 3,
  parameter int unsigned T_RP      = 3,
  parameter int unsigned T_MRD     = 2,
  parameter int unsigned BURST_LEN = 4,
  localparam int unsigned NUM_BANKS = 1 << BA_W
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cs_n_i,
  input logic            ras_n_i,
  input logic            cas_n_i,
  input logic            we_n_i,
  input logic [BA_W-1:0] ba_i,
  input logic            ap_i
);
  localparam int unsigned CW = $clog2(BURST_LEN + T_RP + T_RCD + T_MRD + 1) + 1;
  localparam logic [CW-1:0] SAT = '1;

  logic [3:0] c;
  logic       is_rw, is_exec;
  assign c       = {cs_n_i, ras_n_i, cas_n_i, we_n_i};
  assign is_rw   = (c == CMD_RD) || (c == CMD_WR);
  assign is_exec = !c[3] && (c != CMD_NOP);

  // open-bank shadow rebuilt from the pins only
  logic [NUM_BANKS-1:0] sh_open;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_open <= '0;
    else if (c == CMD_ACT) sh_open[ba_i] <= 1'b1;
    else if (c == CMD_PRE && ap_i) sh_open <= '0;
    else if ((c == CMD_PRE) || (is_rw && ap_i)) sh_open[ba_i] <= 1'b0;
  end

  logic [CW-1:0] mrd_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mrd_cnt <= SAT;
    else if (c == CMD_LMR) mrd_cnt <= CW'(1);
    else if (mrd_cnt != SAT) mrd_cnt <= mrd_cnt + 1'b1;
  end

  AST_LMR_ALL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c == CMD_LMR) |-> (sh_open == '0)) else $error("lmr with open bank"); // R8
  AST_ACT_ON_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c == CMD_ACT) |-> !sh_open[ba_i]) else $error("act on open bank"); // R5
  AST_RW_ON_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rw |-> sh_open[ba_i]) else $error("access to closed bank"); // R4
  AST_MRD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_exec |-> (mrd_cnt >= CW'(T_MRD))) else $error("mrd gap"); // R9

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic          here;
    logic [CW-1:0] rcd_cnt, rp_cnt, rp_need;
    assign here = (ba_i == BA_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rcd_cnt <= SAT;
        rp_cnt  <= SAT;
        rp_need <= '0;
      end else begin
        if (c == CMD_ACT && here) rcd_cnt <= CW'(1);
        else if (rcd_cnt != SAT)  rcd_cnt <= rcd_cnt + 1'b1;
        if ((c == CMD_PRE) && (here || ap_i)) begin
          rp_cnt  <= CW'(1);
          rp_need <= CW'(T_RP);
        end else if (is_rw && ap_i && here) begin
          rp_cnt  <= CW'(1);
          rp_need <= CW'(BURST_LEN + T_RP);
        end else if (rp_cnt != SAT) begin
          rp_cnt <= rp_cnt + 1'b1;
        end
      end
    end

    AST_RCD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_rw && here) |-> (rcd_cnt >= CW'(T_RCD))) else $error("rcd gap"); // R3
    AST_RP_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (c == CMD_ACT && here) |-> (rp_cnt >= rp_need)) else $error("rp gap"); // R7
  end
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
  .BA_W(BA_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_MRD(T_MRD), .BURST_LEN(BURST_LEN)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_n_i  (sd_cs_no),
  .ras_n_i (sd_ras_no),
  .cas_n_i (sd_cas_no),
  .we_n_i  (sd_we_no),
  .ba_i    (sd_ba_o),
  .ap_i    (sd_addr_o[AP_BIT])
);

// File: tb/sim_sdram_cmd_seq.sv
`timescale 1ns/1ps
module sim_sdram_cmd_seq;
  import sdram_seq_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int P_RCD = 2, P_RP = 3, P_MRD = 4, P_BL = 2;
  localparam int BA_W = 2, ROW_W = 12, COL_W = 9, AP_BIT = 10, NB = 4;
  localparam int LOGN = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready, req_ap = 1'b0;
  logic [1:0] req_op = '0;
  logic [BA_W-1:0] req_bank = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic cs_n, ras_n, cas_n, we_n;
  logic [BA_W-1:0] ba;
  logic [ROW_W-1:0] addr;

  sdram_cmd_seq #(
    .BA_W(BA_W), .ROW_W(ROW_W), .COL_W(COL_W), .AP_BIT(AP_BIT),
    .T_RCD(P_RCD), .T_RP(P_RP), .T_MRD(P_MRD), .BURST_LEN(P_BL)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_bank_i(req_bank), .req_row_i(req_row), .req_col_i(req_col),
    .req_ap_i(req_ap), .sd_cs_no(cs_n), .sd_ras_no(ras_n), .sd_cas_no(cas_n),
    .sd_we_no(we_n), .sd_ba_o(ba), .sd_addr_o(addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // command log taken from the pins
  logic [3:0]       lg_cmd [LOGN];
  logic [BA_W-1:0]  lg_ba  [LOGN];
  logic [ROW_W-1:0] lg_addr[LOGN];
  int               lg_cyc [LOGN];
  bit               lg_inh [LOGN];
  int  nlog = 0;
  bit  inh_f = 1'b0;
  logic [3:0] mon_c;

  always @(negedge clk) begin
    mon_c = {cs_n, ras_n, cas_n, we_n};
    if (mon_c[3]) inh_f = 1'b1;
    else if (mon_c != CMD_NOP) begin
      if (nlog < LOGN) begin
        lg_cmd[nlog] = mon_c; lg_ba[nlog] = ba; lg_addr[nlog] = addr;
        lg_cyc[nlog] = cyc;   lg_inh[nlog] = inh_f;
      end
      nlog++;
      inh_f = 1'b0;
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", rq, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  // reference model
  bit m_open[NB];
  int m_row[NB];
  int ap_cyc[NB];
  bit ap_pend[NB];
  int lmr_cyc = 0;
  bit lmr_pend = 1'b0;

  task automatic do_req(input int op, input int b, input int r, input int c, input bit ap);
    logic [3:0] e_cmd[3];
    int e_ba[3], e_addr[3];
    int n = 0, start, guard;
    bit any_open = 1'b0;
    for (int k = 0; k < NB; k++) any_open |= m_open[k];
    if (op >= 2) begin
      if (any_open) begin e_cmd[n] = CMD_PRE; e_ba[n] = 0; e_addr[n] = 1 << AP_BIT; n++; end
      e_cmd[n] = CMD_LMR; e_ba[n] = b; e_addr[n] = r; n++;
    end else begin
      if (!(m_open[b] && m_row[b] == r)) begin
        if (m_open[b]) begin e_cmd[n] = CMD_PRE; e_ba[n] = b; e_addr[n] = 0; n++; end
        e_cmd[n] = CMD_ACT; e_ba[n] = b; e_addr[n] = r; n++;
      end
      e_cmd[n] = (op == 1) ? CMD_WR : CMD_RD; e_ba[n] = b;
      e_addr[n] = c | (int'(ap) << AP_BIT); n++;
    end
    guard = 0;
    while (!req_ready && guard < 200) begin tick(); guard++; end
    start = nlog;
    req_valid = 1'b1; req_op = 2'(op); req_bank = BA_W'(b);
    req_row = ROW_W'(r); req_col = COL_W'(c); req_ap = ap;
    tick();
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R2 ready low while request held", int'(req_ready), 0);
    guard = 0;
    while (nlog < start + n && guard < 200) begin tick(); guard++; end
    chk(nlog == start + n, "R1 command count", nlog - start, n);
    for (int i = 0; i < n; i++) begin
      string tg;
      tg = (op >= 2) ? "R8" : (n == 1 ? "R4" : (n == 3 ? "R5" : "R3"));
      if (e_cmd[i] == CMD_RD || e_cmd[i] == CMD_WR) tg = {tg, "/R6"};
      chk(lg_cmd[start+i] == e_cmd[i], {tg, " command code"}, int'(lg_cmd[start+i]), int'(e_cmd[i]));
      chk(int'(lg_ba[start+i]) == e_ba[i], {tg, " bank"}, int'(lg_ba[start+i]), e_ba[i]);
      chk(int'(lg_addr[start+i]) == e_addr[i], {tg, " address"}, int'(lg_addr[start+i]), e_addr[i]);
      if (i > 0) begin
        int gap = lg_cyc[start+i] - lg_cyc[start+i-1];
        int eg = (e_cmd[i-1] == CMD_ACT) ? P_RCD : P_RP;
        chk(gap == eg, {tg, " spacing"}, gap, eg);
        chk(lg_inh[start+i] == 1'b0, "R1 NOP on wait cycles", int'(lg_inh[start+i]), 0);
      end
    end
    if (lmr_pend) begin
      chk(lg_cyc[start] - lmr_cyc >= P_MRD, "R9 gap after mode load", lg_cyc[start] - lmr_cyc, P_MRD);
      lmr_pend = 1'b0;
    end
    if (op < 2 && ap_pend[b] && e_cmd[0] == CMD_ACT) begin
      chk(lg_cyc[start] - ap_cyc[b] >= P_BL + P_RP, "R7 reopen after auto-precharge",
          lg_cyc[start] - ap_cyc[b], P_BL + P_RP);
      ap_pend[b] = 1'b0;
    end
    // model update and ready timing
    if (op >= 2) begin
      for (int k = 0; k < NB; k++) m_open[k] = 1'b0;
      lmr_cyc = lg_cyc[start+n-1]; lmr_pend = 1'b1;
      for (int k = 0; k < P_MRD - 1; k++) begin
        chk(req_ready == 1'b0, "R9 ready low after mode load", int'(req_ready), 0);
        tick();
      end
      chk(req_ready == 1'b1, "R9 ready returns after mode wait", int'(req_ready), 1);
    end else if (ap) begin
      int w = 0;
      m_open[b] = 1'b0; ap_cyc[b] = lg_cyc[start+n-1]; ap_pend[b] = 1'b1;
      while (!req_ready && w < 100) begin tick(); w++; end
      chk(w == P_BL + P_RP - 1, "R7 ready window after auto-precharge", w, P_BL + P_RP - 1);
    end else begin
      m_open[b] = 1'b1; m_row[b] = r;
      chk(req_ready == 1'b1, "R2 ready back after access", int'(req_ready), 1);
    end
  endtask

  bit done_f = 1'b0;

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done_f) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NB; k++) begin m_open[k] = 0; m_row[k] = 0; ap_cyc[k] = 0; ap_pend[k] = 0; end
    repeat (3) tick();
    chk({cs_n, ras_n, cas_n, we_n} == CMD_INH, "R1 deselect in reset", int'({cs_n, ras_n, cas_n, we_n}), 15);
    rst_n = 1'b1;
    tick();
    chk(req_ready == 1'b1, "R2 ready after reset", int'(req_ready), 1);
    chk(cs_n == 1'b1, "R1 deselect when idle", int'(cs_n), 1);

    for (int b = 0; b < NB; b++) do_req(0, b, 100 + b, 5 + b, 1'b0);       // R3 closed bank
    for (int b = 0; b < NB; b++) do_req(1, b, 100 + b, 300 + b, 1'b0);     // R4 R10 hits
    for (int b = 0; b < NB; b++) do_req(0, b, 200 + b * 7, 17 * b, 1'b0);  // R5 row conflict
    do_req(2, 1, 12'h0A5, 0, 1'b0);                                        // R8 with open banks
    for (int b = 0; b < NB; b++) begin                                     // R7 auto-precharge
      do_req(1, b, 50 * b + 7, 511, 1'b1);
      do_req(0, b, 50 * b + 7, 3, 1'b0);
    end
    for (int b = 0; b < NB; b++) do_req(0, b, 50 * b + 7, 8 * b, 1'b1);    // close all
    do_req(3, 2, 12'h3FF, 0, 1'b0);                                        // R8 all idle
    do_req(1, 3, 4095, 1, 1'b0);                                           // R9 first after mode
    repeat (3) tick();
    chk(cs_n == 1'b1 && ras_n && cas_n && we_n, "R1 deselect after work", int'({cs_n, ras_n, cas_n, we_n}), 15);

    done_f = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule